// File: doc/BRIEF.md
# Cable Reflectometry Test Sequencer

This block runs one reflectometry test on a single-pair cable. A start request sets off a fixed timeline: an optional quiet period, a transmit window in which the modulated test signal is sent, and a second optional quiet period. After that the line is left in forced-link operation. Time is counted from a one-microsecond tick. Each quiet period is chosen by a 2-bit code that maps to 0, 10, 100 or 1000 ms. The transmit window is a 16-bit count of microseconds, and its usual value is 16000.

An external correlator reports candidate reflections while the window is open. Each report carries a tap index, a magnitude, a sign and a 10-bit location. The block keeps the strongest report whose tap lies inside a programmable analysis window. From that report it builds a fault word and a cable verdict: good, open or short. If a link partner disturbs either quiet period, the test ends at once with both done and fail set. All configuration is taken from register inputs when the test starts.

Top module: `refl_test_seq`

## Requirements
- R1: After reset, tx_en, tx_amp, silence, forced_link, busy, stat_word, fault_word and result_code are all zero. At most one of tx_en, silence and forced_link is high in any cycle.
- R2: The pre-quiet phase (silence=1, tx_en=0) lasts code×US_PER_MS ticks, where the code selects 0, 10, 100 or 1000 ms for values 0, 1, 2 and 3. It begins on the clock edge that samples start.
- R3: The transmit phase (tx_en=1) lasts exactly tx_len_us ticks. During it, tx_amp equals the amp_sel value captured at start (0 = low level, 1 = high level).
- R4: The post-quiet phase follows the transmit phase and uses the same code-to-duration mapping. A phase whose length is zero is skipped entirely.
- R5: When the last phase ends, forced_link goes high and stays high. stat_word becomes 2'b10, with done in bit 1 and fail in bit 0.
- R6: line_act high during either quiet phase ends the test on the next edge: forced_link=1 and stat_word=2'b11. line_act has no effect during the transmit phase.
- R7: A start that arrives while busy is high is ignored. The phase timeline carries on unchanged.
- R8: An accepted start clears done, fail and the fault word. This takes effect on the same edge that enters the first phase.
- R9: A correlator report counts only while tx_en is high, only when tap_lo ≤ pk_tap ≤ tap_hi (inclusive), and only when its magnitude is strictly greater than the stored magnitude. fault_word holds detected at bit 11 (stored magnitude nonzero), sign at bit 10 and location at bits 9:0.
- R10: When done is set, result_code gives the verdict: 2'b11 for fail, 2'b01 for open (a peak with sign 1), 2'b10 for short (a peak with sign 0), and 2'b00 for good (no peak). While done is clear, result_code is 2'b00.
- R11: pre_code, post_code, tx_len_us, amp_sel, tap_lo and tap_hi are captured at an accepted start. Changing them during a test has no effect on that test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| start | input | 1 | Test start request (one cycle) |
| pre_code | input | 2 | Pre-quiet duration code |
| post_code | input | 2 | Post-quiet duration code |
| tx_len_us | input | 16 | Transmit window length in microseconds |
| amp_sel | input | 1 | Transmit level select |
| tap_lo | input | 7 | First tap of the analysis window |
| tap_hi | input | 7 | Last tap of the analysis window |
| line_act | input | 1 | Link-partner activity seen on the line |
| pk_valid | input | 1 | Correlator report valid |
| pk_tap | input | 7 | Tap index of the report |
| pk_mag | input | 12 | Magnitude of the report |
| pk_sign | input | 1 | Sign of the reflection |
| pk_loc | input | 10 | Location of the reflection |
| tx_en | output | 1 | Transmit phase active |
| tx_amp | output | 1 | Transmit level, valid with tx_en |
| silence | output | 1 | Quiet phase active |
| forced_link | output | 1 | Test over, line in forced-link operation |
| busy | output | 1 | Test timeline running |
| stat_word | output | 2 | {done, fail} |
| fault_word | output | 12 | {detected, sign, location} |
| result_code | output | 2 | Cable verdict |

## Verification
The assertions assume that reports only ever raise the stored magnitude between starts. They also assume that the tick counter never goes past the length of the phase it is in, which holds only because zero-length phases are skipped before they are entered. The stimulus keeps us_tick high on every cycle so that phase lengths can be counted in clock cycles. It drives start, line_act and the correlator inputs for exactly one cycle at a time, between clock edges. The analysis window is always set with tap_lo no greater than tap_hi.

// File: rtl/refl_pkg.sv
package refl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_PRE  = 3'd1,
    PH_TX   = 3'd2,
    PH_POST = 3'd3,
    PH_LINK = 3'd4
  } phase_e;

  localparam logic [1:0] RES_GOOD  = 2'b00;
  localparam logic [1:0] RES_OPEN  = 2'b01;
  localparam logic [1:0] RES_SHORT = 2'b10;
  localparam logic [1:0] RES_FAIL  = 2'b11;

  // quiet-phase code to milliseconds
  function automatic int unsigned quiet_ms(input logic [1:0] code);
    case (code)
      2'd0:    return 0;
      2'd1:    return 10;
      2'd2:    return 100;
      default: return 1000;
    endcase
  endfunction

endpackage

// File: rtl/refl_phase_ctl.sv
module refl_phase_ctl
  import refl_pkg::*;
#(
  parameter int unsigned US_PER_MS = 1000,
  parameter int unsigned LEN_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic [1:0]       pre_code,
  input  logic [1:0]       post_code,
  input  logic [LEN_W-1:0] tx_len,
  input  logic             line_act,
  output phase_e           phase,
  output logic             busy,
  output logic             launch,
  output logic             done,
  output logic             fail
);

  localparam int unsigned MAX_T = 1000 * US_PER_MS;
  localparam int unsigned SIL_W = $clog2(MAX_T + 1);
  localparam int unsigned CNT_W = (SIL_W > LEN_W) ? SIL_W : LEN_W;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  phase_e           st_q, st_d, after_cur;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] pre_len_q, post_len_q, tx_len_q;
  logic [CNT_W-1:0] in_pre, in_post, in_tx, cur_len;
  logic             done_q, done_d, fail_q, fail_d;
  logic             phase_end, abort;

  // first non-empty phase at or after 'from'
  function automatic phase_e pick(input phase_e from,
                                  input logic [CNT_W-1:0] p,
                                  input logic [CNT_W-1:0] t,
                                  input logic [CNT_W-1:0] q);
    if (from == PH_PRE && p != '0) return PH_PRE;
    if ((from == PH_PRE || from == PH_TX) && t != '0) return PH_TX;
    if (q != '0) return PH_POST;
    return PH_LINK;
  endfunction

  assign in_pre  = CNT_W'(quiet_ms(pre_code) * US_PER_MS);
  assign in_post = CNT_W'(quiet_ms(post_code) * US_PER_MS);
  assign in_tx   = CNT_W'(tx_len);

  assign busy   = (st_q == PH_PRE) || (st_q == PH_TX) || (st_q == PH_POST);
  assign launch = start && !busy;
  assign abort  = line_act && ((st_q == PH_PRE) || (st_q == PH_POST));

  always_comb begin
    case (st_q)
      PH_PRE:  cur_len = pre_len_q;
      PH_TX:   cur_len = tx_len_q;
      PH_POST: cur_len = post_len_q;
      default: cur_len = '0;
    endcase
  end

  assign phase_end = busy && tick && (cnt_q == cur_len - ONE);

  always_comb begin
    case (st_q)
      PH_PRE:  after_cur = pick(PH_TX, pre_len_q, tx_len_q, post_len_q);
      PH_TX:   after_cur = pick(PH_POST, pre_len_q, tx_len_q, post_len_q);
      default: after_cur = PH_LINK;
    endcase
  end

  // next state
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    fail_d = fail_q;
    if (launch) begin
      st_d   = pick(PH_PRE, in_pre, in_tx, in_post);
      cnt_d  = '0;
      done_d = (st_d == PH_LINK);
      fail_d = 1'b0;
    end else if (abort) begin
      st_d   = PH_LINK;
      cnt_d  = '0;
      done_d = 1'b1;
      fail_d = 1'b1;
    end else if (phase_end) begin
      st_d   = after_cur;
      cnt_d  = '0;
      done_d = (after_cur == PH_LINK);
    end else if (busy && tick) begin
      cnt_d = cnt_q + ONE;
    end
  end

  // configuration capture, enabled by launch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_len_q  <= '0;
      post_len_q <= '0;
      tx_len_q   <= '0;
    end else if (launch) begin
      pre_len_q  <= in_pre;
      post_len_q <= in_post;
      tx_len_q   <= in_tx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PH_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      fail_q <= fail_d;
    end
  end

  assign phase = st_q;
  assign done  = done_q;
  assign fail  = fail_q;

  AST_FAIL_IMPLIES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |-> done_q); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q < cur_len)); // R3
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !phase_end && !abort) |=> (st_q == $past(st_q))); // R7
  AST_LAUNCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !fail_q); // R8

endmodule

// File: rtl/refl_peak_track.sv
module refl_peak_track #(
  parameter int unsigned TAP_W = 7,
  parameter int unsigned MAG_W = 12,
  parameter int unsigned LOC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             pk_valid,
  input  logic [TAP_W-1:0] pk_tap,
  input  logic [MAG_W-1:0] pk_mag,
  input  logic             pk_sign,
  input  logic [LOC_W-1:0] pk_loc,
  input  logic [TAP_W-1:0] tap_lo,
  input  logic [TAP_W-1:0] tap_hi,
  output logic             detected,
  output logic             sign,
  output logic [LOC_W-1:0] loc
);

  logic [MAG_W-1:0] mag_q, mag_d;
  logic [LOC_W-1:0] loc_q, loc_d;
  logic             sign_q, sign_d;
  logic             in_win, take;

  assign in_win = (pk_tap >= tap_lo) && (pk_tap <= tap_hi);
  assign take   = en && pk_valid && in_win && (pk_mag > mag_q);

  always_comb begin
    mag_d  = mag_q;
    loc_d  = loc_q;
    sign_d = sign_q;
    if (clr) begin
      mag_d  = '0;
      loc_d  = '0;
      sign_d = 1'b0;
    end else if (take) begin
      mag_d  = pk_mag;
      loc_d  = pk_loc;
      sign_d = pk_sign;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q  <= '0;
      loc_q  <= '0;
      sign_q <= 1'b0;
    end else begin
      mag_q  <= mag_d;
      loc_q  <= loc_d;
      sign_q <= sign_d;
    end
  end

  assign detected = (mag_q != '0);
  assign sign     = sign_q;
  assign loc      = loc_q;

  AST_PEAK_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (mag_q >= $past(mag_q))); // R9
  AST_HOLD_OUTSIDE_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> ($stable(mag_q) && $stable(loc_q) && $stable(sign_q))); // R9

endmodule

// File: rtl/refl_test_seq.sv
module refl_test_seq
  import refl_pkg::*;
#(
  parameter int unsigned US_PER_MS = 1000,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned TAP_W     = 7,
  parameter int unsigned MAG_W     = 12,
  parameter int unsigned LOC_W     = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               us_tick,
  input  logic               start,
  input  logic [1:0]         pre_code,
  input  logic [1:0]         post_code,
  input  logic [LEN_W-1:0]   tx_len_us,
  input  logic               amp_sel,
  input  logic [TAP_W-1:0]   tap_lo,
  input  logic [TAP_W-1:0]   tap_hi,
  input  logic               line_act,
  input  logic               pk_valid,
  input  logic [TAP_W-1:0]   pk_tap,
  input  logic [MAG_W-1:0]   pk_mag,
  input  logic               pk_sign,
  input  logic [LOC_W-1:0]   pk_loc,
  output logic               tx_en,
  output logic               tx_amp,
  output logic               silence,
  output logic               forced_link,
  output logic               busy,
  output logic [1:0]         stat_word,
  output logic [LOC_W+1:0]   fault_word,
  output logic [1:0]         result_code
);

  phase_e           phase;
  logic             launch, done, fail;
  logic             amp_q;
  logic [TAP_W-1:0] tap_lo_q, tap_hi_q;
  logic             pk_det, pk_sgn;
  logic [LOC_W-1:0] pk_at;

  refl_phase_ctl #(
    .US_PER_MS (US_PER_MS),
    .LEN_W     (LEN_W)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (us_tick),
    .start     (start),
    .pre_code  (pre_code),
    .post_code (post_code),
    .tx_len    (tx_len_us),
    .line_act  (line_act),
    .phase     (phase),
    .busy      (busy),
    .launch    (launch),
    .done      (done),
    .fail      (fail)
  );

  // level and analysis window captured at launch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amp_q    <= 1'b0;
      tap_lo_q <= '0;
      tap_hi_q <= '0;
    end else if (launch) begin
      amp_q    <= amp_sel;
      tap_lo_q <= tap_lo;
      tap_hi_q <= tap_hi;
    end
  end

  refl_peak_track #(
    .TAP_W (TAP_W),
    .MAG_W (MAG_W),
    .LOC_W (LOC_W)
  ) u_peak (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (launch),
    .en       (phase == PH_TX),
    .pk_valid (pk_valid),
    .pk_tap   (pk_tap),
    .pk_mag   (pk_mag),
    .pk_sign  (pk_sign),
    .pk_loc   (pk_loc),
    .tap_lo   (tap_lo_q),
    .tap_hi   (tap_hi_q),
    .detected (pk_det),
    .sign     (pk_sgn),
    .loc      (pk_at)
  );

  assign tx_en       = (phase == PH_TX);
  assign tx_amp      = tx_en && amp_q;
  assign silence     = (phase == PH_PRE) || (phase == PH_POST);
  assign forced_link = (phase == PH_LINK);
  assign stat_word   = {done, fail};
  assign fault_word  = {pk_det, pk_sgn, pk_at};

  always_comb begin
    if (!done)       result_code = RES_GOOD;
    else if (fail)   result_code = RES_FAIL;
    else if (!pk_det) result_code = RES_GOOD;
    else if (pk_sgn) result_code = RES_OPEN;
    else             result_code = RES_SHORT;
  end

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_en, silence, forced_link})); // R1
  AST_AMP_ONLY_TX: assert property (@(posedge clk) disable iff (!rst_n)
    tx_amp |-> tx_en); // R3
  AST_LINK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (forced_link && !start) |=> forced_link); // R5

endmodule

// File: tb/refl_test_seq_test.sv
module refl_test_seq_test;

  localparam int unsigned US = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        us_tick, start, amp_sel, line_act;
  logic [1:0]  pre_code, post_code;
  logic [15:0] tx_len_us;
  logic [6:0]  tap_lo, tap_hi, pk_tap;
  logic        pk_valid, pk_sign;
  logic [11:0] pk_mag;
  logic [9:0]  pk_loc;
  logic        tx_en, tx_amp, silence, forced_link, busy;
  logic [1:0]  stat_word, result_code;
  logic [11:0] fault_word;

  int n_chk = 0;
  int n_err = 0;
  int m_pre, m_tx, m_post, m_ampbad;

  always #10 clk = ~clk;

  refl_test_seq #(.US_PER_MS(US)) uut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start(start),
    .pre_code(pre_code), .post_code(post_code), .tx_len_us(tx_len_us),
    .amp_sel(amp_sel), .tap_lo(tap_lo), .tap_hi(tap_hi), .line_act(line_act),
    .pk_valid(pk_valid), .pk_tap(pk_tap), .pk_mag(pk_mag), .pk_sign(pk_sign),
    .pk_loc(pk_loc), .tx_en(tx_en), .tx_amp(tx_amp), .silence(silence),
    .forced_link(forced_link), .busy(busy), .stat_word(stat_word),
    .fault_word(fault_word), .result_code(result_code)
  );

  // {pre, post, amp, len}
  localparam logic [20:0] VEC [7] = '{
    {2'd0, 2'd0, 1'b1, 16'd5},
    {2'd1, 2'd0, 1'b0, 16'd3},
    {2'd0, 2'd1, 1'b1, 16'd1},
    {2'd2, 2'd1, 1'b1, 16'd7},
    {2'd3, 2'd2, 1'b0, 16'd4},
    {2'd1, 2'd1, 1'b0, 16'd0},
    {2'd0, 2'd0, 1'b0, 16'd0}
  };

  function automatic int exp_ticks(input logic [1:0] c);
    case (c)
      2'd0: return 0;
      2'd1: return 10 * US;
      2'd2: return 100 * US;
      default: return 1000 * US;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run_seq(input logic [1:0] pre, input logic [1:0] post,
                         input logic [15:0] len, input logic amp,
                         input int chg_at, input int act_at);
    int idx;
    logic seen_tx;
    pre_code = pre; post_code = post; tx_len_us = len; amp_sel = amp;
    m_pre = 0; m_tx = 0; m_post = 0; m_ampbad = 0; seen_tx = 1'b0; idx = 0;
    pulse_start();
    while (!forced_link && idx < 20000) begin
      if (tx_en) begin
        m_tx++; seen_tx = 1'b1;
        if (tx_amp !== amp) m_ampbad++;
      end else if (silence) begin
        if (seen_tx) m_post++; else m_pre++;
      end
      if (idx == chg_at) begin
        pre_code = 2'd3; post_code = 2'd3; tx_len_us = 16'd900;
        amp_sel = ~amp; tap_lo = 7'd0; start = 1'b1;
      end
      if (idx == act_at) line_act = 1'b1;
      @(negedge clk);
      start = 1'b0; line_act = 1'b0; idx++;
    end
  endtask

  task automatic sample(input logic [6:0] tap, input logic [11:0] mag,
                        input logic sg, input logic [9:0] loc);
    pk_valid = 1'b1; pk_tap = tap; pk_mag = mag; pk_sign = sg; pk_loc = loc;
    @(negedge clk);
    pk_valid = 1'b0;
  endtask

  task automatic wait_link();
    for (int i = 0; i < 5000 && !forced_link; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; us_tick = 1'b1; start = 1'b0; line_act = 1'b0;
    pre_code = 0; post_code = 0; tx_len_us = 0; amp_sel = 0;
    tap_lo = 7'd4; tap_hi = 7'd36;
    pk_valid = 0; pk_tap = 0; pk_mag = 0; pk_sign = 0; pk_loc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 outputs", {tx_en, tx_amp, silence, forced_link, busy}, 0);
    check("R1 stat", stat_word, 0);
    check("R1 fault", fault_word, 0);
    check("R1 result", result_code, 0);

    // table of timelines: R2 R3 R4 R5
    foreach (VEC[i]) begin
      logic [1:0] p, q; logic a; logic [15:0] l;
      {p, q, a, l} = VEC[i];
      run_seq(p, q, l, a, -1, -1);
      if (l != 0) begin
        check("R2 pre length", m_pre, exp_ticks(p));
        check("R4 post length", m_post, exp_ticks(q));
      end else begin
        check("R4 skipped tx quiet total", m_pre + m_post, exp_ticks(p) + exp_ticks(q));
      end
      check("R3 tx length", m_tx, l);
      check("R3 amplitude", m_ampbad, 0);
      check("R5 forced link", forced_link, 1);
      check("R5 done no fail", stat_word, 2);
    end

    // R7 R11: restart and config change inside the transmit window
    run_seq(2'd1, 2'd0, 16'd10, 1'b1, 25, -1);
    check("R11 pre", m_pre, 20);
    check("R7 tx unchanged", m_tx, 10);
    check("R11 post", m_post, 0);
    check("R11 amp", m_ampbad, 0);
    check("R7 done", stat_word, 2);
    tap_lo = 7'd4;

    // R6 activity in pre-quiet
    run_seq(2'd1, 2'd1, 16'd5, 1'b0, -1, 5);
    check("R6 pre abort point", m_pre, 6);
    check("R6 no tx", m_tx, 0);
    check("R6 stat fail", stat_word, 3);
    check("R10 fail code", result_code, 3);
    // R6 activity in post-quiet
    run_seq(2'd0, 2'd1, 16'd4, 1'b0, -1, 7);
    check("R6 post abort point", m_post, 4);
    check("R6 stat post fail", stat_word, 3);
    // R6 activity during tx ignored
    run_seq(2'd0, 2'd1, 16'd10, 1'b0, -1, 3);
    check("R6 tx ignores activity", m_tx, 10);
    check("R6 post full", m_post, 20);
    check("R6 no fail", stat_word, 2);

    // R9 R10 open case
    pre_code = 0; post_code = 1; tx_len_us = 16'd40; amp_sel = 0;
    pulse_start();
    check("R8 cleared on start", stat_word, 0);
    check("R8 fault cleared", fault_word, 0);
    check("R10 code while running", result_code, 0);
    sample(7'd10, 12'd5, 1'b1, 10'd100);
    sample(7'd40, 12'd50, 1'b0, 10'd400);
    sample(7'd36, 12'd7, 1'b1, 10'd222);
    sample(7'd3, 12'd60, 1'b0, 10'd9);
    sample(7'd20, 12'd7, 1'b0, 10'd300);
    sample(7'd4, 12'd6, 1'b0, 10'd11);
    for (int i = 0; i < 100 && !silence; i++) @(negedge clk);
    sample(7'd12, 12'd99, 1'b0, 10'd500);
    wait_link();
    check("R9 fault word open", fault_word, {1'b1, 1'b1, 10'd222});
    check("R10 open", result_code, 1);

    // short case
    pulse_start();
    check("R9 fault cleared again", fault_word, 0);
    sample(7'd4, 12'd3, 1'b0, 10'd17);
    sample(7'd25, 12'd9, 1'b0, 10'd77);
    wait_link();
    check("R9 fault word short", fault_word, {1'b1, 1'b0, 10'd77});
    check("R10 short", result_code, 2);

    // good case
    pulse_start();
    wait_link();
    check("R9 no peak", fault_word, 0);
    check("R10 good", result_code, 0);
    check("R5 good done", stat_word, 2);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule